// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is a single 32-bit control and status word on a simple register bus. Software uses it to choose which deep low-power mode a sleep request leads to, and to control how the brown-out detector behaves. The block passes brown-out enable and brown-out reset enable levels to the analog side. It also passes a decoded mode request to a power sequencer. The sequencer reports each mode it actually enters with an entry strobe.

Each entry is recorded in a sticky flag. At most one flag is set at a time. Software clears a flag by writing a one to its bit. The flags live outside the ordinary reset. Three of them are cleared only by a core power-on or brown-out reset input. The deepest one is cleared only by a battery-domain power-on reset input. The block keeps track of the low-power mode the chip is in, from the entry strobe until a wake strobe. The brown-out gating for reduced-power operation depends on that mode.

Top module: `pmc_top`

## Requirements
- R1: After ordinary reset `rst`, control bits 4:0 read 0, `req_vld` is 0, `bo_en` is 1 and `bo_rst_en` is 1.
- R2: A write with `bus_addr` equal to `REG_ADDR` loads bits 4:0 of the word: bit 0 requests power-down, bit 1 requests deep power-down, bit 2 turns the detector off in reduced-power modes, bit 3 turns it off always, and bit 4 blocks the brown-out reset. Read data appears in `bus_rdata` on the cycle after the address is presented. Any other address reads 0, and writes to it change nothing.
- R3: Bits 7:5 and 31:12 ignore writes and always read 0.
- R4: While bit 3 is 1, `bo_en` is 0 in every mode.
- R5: While bit 2 is 1 and the recorded mode is deep sleep or power-down, `bo_en` is 0. In sleep, deep power-down or run it stays 1. It returns to 1 after `wake_stb`.
- R6: `bo_rst_en` is 0 whenever bit 4 is 1 or `bo_en` is 0, and 1 otherwise.
- R7: A `slp_req` strobe produces a one-cycle `req_vld` pulse on the next cycle, with `req_mode` set as follows. The codes are 0 for sleep, 1 for deep sleep, 2 for power-down and 3 for deep power-down. With `deep_in` low the mode is sleep. With `deep_in` high the PM bits {bit1,bit0} select the mode: 00 gives deep sleep, 01 power-down, 11 deep power-down, and 10 deep sleep.
- R8: An `ent_stb` with code `ent_mode` sets flag bit 8+code on the next cycle and clears the other three flags. Bit 8 is sleep, 9 deep sleep, 10 power-down and 11 deep power-down.
- R9: Writing a one to a flag bit clears it. Writing a zero leaves it unchanged.
- R10: If an entry strobe and a write-one-to-clear of the same flag happen in the same cycle, the flag ends up set.
- R11: `rst` leaves the flags unchanged. `core_por` clears bits 8 to 10 but not bit 11. Only `bat_por` clears bit 11.
- R12: At most one flag bit is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Ordinary synchronous reset, active high |
| core_por | input | 1 | Core power-on or brown-out reset for flags 8 to 10 |
| bat_por | input | 1 | Battery-domain power-on reset for flag 11 |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| slp_req | input | 1 | Sleep request strobe |
| deep_in | input | 1 | Deep-sleep qualifier for the request |
| ent_stb | input | 1 | Mode-entered strobe from the sequencer |
| ent_mode | input | 2 | Code of the mode entered |
| wake_stb | input | 1 | Chip has returned to run |
| req_vld | output | 1 | Mode request valid pulse |
| req_mode | output | 2 | Requested mode code |
| bo_en | output | 1 | Brown-out detector enable |
| bo_rst_en | output | 1 | Brown-out second-stage reset enable |

## Verification
Some properties are checked by assertions on every cycle: the flags are one-hot-or-zero, an entry strobe sets exactly its own flag, a clear without an entry touches only the written ones, a foreign write leaves the control bits alone, and a request turns into a pulse one cycle later. Other behaviour shows only in the bench's scenarios. That covers the full decode across every PM combination, the brown-out gating in each recorded mode, the separate reset domains of the flags, and the read-back of reserved bits after writes of all ones.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_FLAGS = 4;
    localparam int unsigned FLAG_LSB  = 8;
    localparam int unsigned CTRL_W    = 5;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_DSLEEP = 2'd1,
        MODE_PDOWN  = 2'd2,
        MODE_DPDOWN = 2'd3
    } lp_mode_e;

    // field order matches word bits 4..0
    typedef struct packed {
        logic bo_rst_off;
        logic bo_off;
        logic bo_lp_off;
        logic pm1;
        logic pm0;
    } ctrl_t;

    typedef struct packed {
        logic     vld;
        lp_mode_e mode;
    } act_t;

    function automatic lp_mode_e decode_req(logic deep, logic pm1, logic pm0);
        if (!deep)           return MODE_SLEEP;
        else if (pm1 && pm0) return MODE_DPDOWN;
        else if (pm0)        return MODE_PDOWN;
        else                 return MODE_DSLEEP;
    endfunction

    function automatic logic [NUM_FLAGS-1:0] mode_onehot(lp_mode_e m);
        return NUM_FLAGS'(1) << m;
    endfunction
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [NUM_FLAGS-1:0] flags,
    output ctrl_t                ctrl,
    output logic [NUM_FLAGS-1:0] w1c,
    output logic [DATA_W-1:0]    bus_rdata
);
    logic hit, wr_hit;
    logic [DATA_W-1:0] word;

    assign hit    = (bus_addr == REG_ADDR);
    assign wr_hit = hit && bus_we;
    assign w1c    = wr_hit ? bus_wdata[FLAG_LSB +: NUM_FLAGS] : '0;

    always_ff @(posedge clk) begin
        if (rst)         ctrl <= '0;
        else if (wr_hit) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        word = '0;
        word[CTRL_W-1:0] = ctrl;
        word[FLAG_LSB +: NUM_FLAGS] = flags;
    end

    always_ff @(posedge clk) begin
        if (rst)      bus_rdata <= '0;
        else if (hit) bus_rdata <= word;
        else          bus_rdata <= '0;
    end

    p_foreign_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !hit) |=> $stable(ctrl));
endmodule

// File: rtl/pmc_flags.sv
module pmc_flags
    import pmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 core_por,
    input  logic                 bat_por,
    input  logic                 ent_stb,
    input  lp_mode_e             ent_mode,
    input  logic [NUM_FLAGS-1:0] w1c,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [NUM_FLAGS-1:0] set_vec;
    assign set_vec = mode_onehot(ent_mode);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic por_i;
        if (i == NUM_FLAGS-1) begin : g_bat
            assign por_i = bat_por;
        end else begin : g_core
            assign por_i = core_por;
        end
        always_ff @(posedge clk) begin
            if (por_i)        flags[i] <= 1'b0;
            else if (ent_stb) flags[i] <= set_vec[i];
            else if (w1c[i])  flags[i] <= 1'b0;
        end
    end

    p_onehot_r12: assert property (@(posedge clk) disable iff (core_por || bat_por)
        $onehot0(flags));
    p_entry_sets_r10: assert property (@(posedge clk) disable iff (core_por || bat_por)
        ent_stb |=> (flags == (NUM_FLAGS'(1) << $past(ent_mode))));
    p_clear_only_r9: assert property (@(posedge clk) disable iff (core_por || bat_por)
        !ent_stb |=> ((flags & $past(w1c)) == '0) && ((flags & ~$past(w1c)) == ($past(flags) & ~$past(w1c))));
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctrl_t    ctrl,
    input  logic     slp_req,
    input  logic     deep_in,
    input  logic     ent_stb,
    input  lp_mode_e ent_mode,
    input  logic     wake_stb,
    output logic     req_vld,
    output lp_mode_e req_mode,
    output logic     bo_en,
    output logic     bo_rst_en
);
    act_t act;
    logic lp_gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_vld  <= 1'b0;
            req_mode <= MODE_SLEEP;
        end else begin
            req_vld <= slp_req;
            if (slp_req) req_mode <= decode_req(deep_in, ctrl.pm1, ctrl.pm0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           act <= '{vld: 1'b0, mode: MODE_SLEEP};
        else if (ent_stb)  act <= '{vld: 1'b1, mode: ent_mode};
        else if (wake_stb) act.vld <= 1'b0;
    end

    assign lp_gate   = act.vld && (act.mode == MODE_DSLEEP || act.mode == MODE_PDOWN);
    assign bo_en     = !ctrl.bo_off && !(ctrl.bo_lp_off && lp_gate);
    assign bo_rst_en = bo_en && !ctrl.bo_rst_off;

    p_sleep_req_r7: assert property (@(posedge clk) disable iff (rst)
        (slp_req && !deep_in) |=> (req_vld && req_mode == MODE_SLEEP));
    p_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        !slp_req |=> !req_vld);
    p_lp_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (ent_stb && ctrl.bo_lp_off && (ent_mode == MODE_DSLEEP || ent_mode == MODE_PDOWN))
        |=> !bo_en);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h0C0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_por,
    input  logic              bat_por,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              slp_req,
    input  logic              deep_in,
    input  logic              ent_stb,
    input  logic [1:0]        ent_mode,
    input  logic              wake_stb,
    output logic              req_vld,
    output logic [1:0]        req_mode,
    output logic              bo_en,
    output logic              bo_rst_en
);
    ctrl_t                ctrl;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] w1c;
    lp_mode_e             req_mode_e;
    lp_mode_e             ent_mode_e;

    assign ent_mode_e = lp_mode_e'(ent_mode);
    assign req_mode   = req_mode_e;

    pmc_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .flags(flags), .ctrl(ctrl), .w1c(w1c),
        .bus_rdata(bus_rdata)
    );

    pmc_flags u_flags (
        .clk(clk), .core_por(core_por), .bat_por(bat_por), .ent_stb(ent_stb),
        .ent_mode(ent_mode_e), .w1c(w1c), .flags(flags)
    );

    pmc_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .slp_req(slp_req), .deep_in(deep_in),
        .ent_stb(ent_stb), .ent_mode(ent_mode_e), .wake_stb(wake_stb),
        .req_vld(req_vld), .req_mode(req_mode_e), .bo_en(bo_en), .bo_rst_en(bo_rst_en)
    );

    p_global_off_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_ADDR && bus_wdata[3]) |=> !bo_en);
    p_rst_block_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_ADDR && bus_wdata[4]) |=> !bo_rst_en);
endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
    localparam int unsigned ADDR_W = 12;
    localparam logic [ADDR_W-1:0] RA = 12'h0C0;

    logic clk = 0, rst = 1, core_por = 1, bat_por = 1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_we = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic slp_req = 0, deep_in = 0, ent_stb = 0, wake_stb = 0;
    logic [1:0] ent_mode = '0, req_mode;
    logic req_vld, bo_en, bo_rst_en;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pmc_top #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) dut (.*);

    // {ctrl[4:0], deep, exp_mode[1:0], exp_bo_en_in_mode, exp_bo_rst_en_in_mode}
    localparam int NV = 9;
    localparam logic [9:0] VEC [NV] = '{
        {5'b00000, 1'b0, 2'd0, 1'b1, 1'b1},
        {5'b00100, 1'b0, 2'd0, 1'b1, 1'b1},
        {5'b00100, 1'b1, 2'd1, 1'b0, 1'b0},
        {5'b00101, 1'b1, 2'd2, 1'b0, 1'b0},
        {5'b00011, 1'b1, 2'd3, 1'b1, 1'b1},
        {5'b00010, 1'b1, 2'd1, 1'b1, 1'b1},
        {5'b01000, 1'b0, 2'd0, 1'b0, 1'b0},
        {5'b10001, 1'b1, 2'd2, 1'b1, 1'b0},
        {5'b00001, 1'b0, 2'd0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk); bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 0;
        cyc(); d = bus_rdata;
    endtask

    task automatic enter(input logic [1:0] m);
        @(negedge clk); ent_stb = 1; ent_mode = m;
        @(negedge clk); ent_stb = 0;
    endtask

    task automatic wake;
        @(negedge clk); wake_stb = 1;
        @(negedge clk); wake_stb = 0;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0; core_por = 0; bat_por = 0;
        rd(RA, d);
        chk("R1 reset word", d, 32'h0);
        chk("R1 reset bo_en", {31'b0, bo_en}, 32'h1);
        chk("R1 reset bo_rst_en", {31'b0, bo_rst_en}, 32'h1);
        chk("R1 reset req_vld", {31'b0, req_vld}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [4:0] c; logic dp; logic [1:0] m; logic eb, er;
            {c, dp, m, eb, er} = VEC[i];
            wr(RA, {27'b0, c});
            rd(RA, d);
            chk("R2 ctrl readback", d, {27'b0, c});
            @(negedge clk); slp_req = 1; deep_in = dp;
            cyc();
            chk("R7 req_vld pulse", {31'b0, req_vld}, 32'h1);
            chk("R7 req_mode", {30'b0, req_mode}, {30'b0, m});
            @(negedge clk); slp_req = 0; deep_in = 0;
            cyc();
            chk("R7 pulse one cycle", {31'b0, req_vld}, 32'h0);
            enter(m);
            chk("R5 R4 bo_en in mode", {31'b0, bo_en}, {31'b0, eb});
            chk("R6 bo_rst_en in mode", {31'b0, bo_rst_en}, {31'b0, er});
            rd(RA, d);
            chk("R8 flag set", d, {20'b0, 4'b0001 << m, 3'b0, c});
            wake;
            chk("R5 bo_en after wake", {31'b0, bo_en}, {31'b0, !c[3]});
            wr(RA, 32'h0000_0F00);
            rd(RA, d);
            chk("R9 flags cleared", d, 32'h0);
        end

        // R3 reserved bits
        wr(RA, 32'hFFFF_FFFF);
        rd(RA, d);
        chk("R3 reserved read zero", d, 32'h0000_001F);
        wr(RA, 32'h0);
        // R2 other address
        wr(RA + 12'h4, 32'h0000_0008);
        chk("R2 foreign write ignored", {31'b0, bo_en}, 32'h1);
        rd(RA + 12'h4, d);
        chk("R2 foreign read zero", d, 32'h0);
        // R8 entry clears others
        enter(2'd1);
        enter(2'd2);
        rd(RA, d);
        chk("R8 one-hot replace", d, 32'h0000_0400);
        // R9 zero write no effect
        wr(RA, 32'h0000_0B00);
        rd(RA, d);
        chk("R9 write zero keeps", d, 32'h0000_0400);
        // R10 same cycle set and clear
        @(negedge clk); ent_stb = 1; ent_mode = 2'd0;
        bus_addr = RA; bus_we = 1; bus_wdata = 32'h0000_0F00;
        @(negedge clk); ent_stb = 0; bus_we = 0; bus_wdata = '0;
        rd(RA, d);
        chk("R10 set wins", d, 32'h0000_0100);
        // R11 domains
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        rd(RA, d);
        chk("R11 rst keeps flag", d, 32'h0000_0100);
        @(negedge clk); core_por = 1; @(negedge clk); core_por = 0;
        rd(RA, d);
        chk("R11 core_por clears", d, 32'h0);
        enter(2'd3);
        @(negedge clk); core_por = 1; @(negedge clk); core_por = 0;
        rd(RA, d);
        chk("R11 core_por keeps bit 11", d, 32'h0000_0800);
        @(negedge clk); bat_por = 1; @(negedge clk); bat_por = 0;
        rd(RA, d);
        chk("R11 bat_por clears bit 11", d, 32'h0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule